// File: doc/BRIEF.md
# Enable-Qualified Counter PWM Generator

This block turns a 4-bit duty value into a pulse-width-modulated line. A 4-bit
counter advances once per enabled clock and rolls over every 16 enabled cycles.
The output is high for the first D cycles of each period, where D is the duty
value captured for that period. When the enable input is low, no register in
the block changes: count, captured duty, output and flag all hold.

The counter is a Mealy machine. Its next output depends on both its current
count and the live duty input at the moment of rollover, so a fresh duty value
takes effect in the very first cycle of the new period. The duty input is
sampled only on that rollover cycle, which keeps the pulse free of
mid-period glitches. A flag marks the first cycle of every period. The usual
gated register clock is expressed as a clock enable on every flop, so the
block needs only one free-running clock.

Top module: `pwmg_gated_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears its count and captured duty to 0 and drives `pwm_o` and `wrap_o` low after that edge, whatever `en` is.
- R2: A rising edge with `en` low changes nothing: `pwm_o`, `wrap_o` and the internal count and duty keep their values, so the pulse pattern resumes exactly where it stopped.
- R3: The period is 16 enabled cycles; `wrap_o` is high for exactly the one enabled cycle that follows the count rolling from 15 to 0, and low otherwise.
- R4: Counting enabled cycles from each rollover as positions 0 to 15, `pwm_o` is high at positions below the captured duty D and low at positions D to 15.
- R5: `duty_in` is captured only on the enabled edge at which the count rolls from 15 to 0; its value at any other edge has no effect on `pwm_o`.
- R6: A captured duty of 0 holds `pwm_o` low for the whole period; a captured duty of 15 gives 15 high cycles and one low cycle per period.
- R7: After reset the captured duty is 0, so the first period after reset is entirely low, whatever `duty_in` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock qualifier; registers update only while high |
| duty_in | input | 4 | Duty value, unsigned, sampled at rollover |
| pwm_o | output | 1 | Registered PWM line |
| wrap_o | output | 1 | One-cycle period-start flag |

## Verification
On every cycle the assertions check that a disabled edge leaves the count and the captured duty unchanged, that the count steps by one per enabled edge, that the captured duty moves only on a rollover edge, that a zero duty never produces a high output and that the flag never stays high across two enabled edges. Whether the pulse has the right width for every duty value, whether a duty change mid-period is really ignored, and whether the pattern resumes correctly after stretches of disabled cycles and mid-run resets can only be shown by the bench's sweeps, which compare both outputs with an arithmetic model on every cycle.

// File: rtl/pwmg_pkg.sv
// pwmg_pkg: shared helpers for the enable-qualified PWM generator.
// Assumes the counter width is at least 2 bits.
package pwmg_pkg;

    // Number of enabled cycles in one PWM period for a given counter width.
    function automatic int unsigned period_len(input int unsigned width);
        return 32'd1 << width;
    endfunction

    // Per-cycle status that the counter hands to the other stages.
    typedef struct packed {
        logic roll;   // enabled edge on which the count goes from max to 0
        logic step;   // enabled edge (count advances)
    } cnt_evt_t;

endpackage

// File: rtl/pwmg_counter.sv
// pwmg_counter: period counter, one state per count value (Mealy machine).
// The count advances on every enabled edge and wraps at its maximum.
// Assumes rst_n is synchronous and active low; en acts as the register clock
// qualifier, so nothing changes while en is low.
module pwmg_counter
    import pwmg_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output cnt_evt_t         evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Mealy event decode: depends on current state and the enable input.
    always_comb begin
        evt.step = en;
        evt.roll = en && (cnt_q == CNT_MAX);
        cnt_nxt  = evt.step ? cnt_q + 1'b1 : cnt_q;
    end

    // Count register with synchronous reset and enable qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt.step) begin
            cnt_q <= cnt_nxt;
        end
    end

    // A disabled edge leaves the count untouched.
    assert_count_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));

    // Each enabled edge moves the count by exactly one, modulo the period.
    assert_count_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        en && (cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    assert_count_roll_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        en && (cnt_q == CNT_MAX) |=> cnt_q == '0);

endmodule

// File: rtl/pwmg_duty_latch.sv
// pwmg_duty_latch: holds the duty value used for the current period.
// Captures the live duty input only on the rollover edge and offers the
// value that will be in force after the next edge (Mealy look-ahead).
// Assumes roll is already qualified by the enable.
module pwmg_duty_latch #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             roll,
    input  logic [CNT_W-1:0] duty_in,
    output logic [CNT_W-1:0] duty_q,
    output logic [CNT_W-1:0] duty_nxt
);

    // Look-ahead: the duty that governs the cycle after this edge.
    always_comb begin
        duty_nxt = roll ? duty_in : duty_q;
    end

    // Captured duty register, loaded only on rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (roll) begin
            duty_q <= duty_in;
        end
    end

    // Outside a rollover edge the captured duty never moves.
    assert_duty_frozen_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(duty_q));

endmodule

// File: rtl/pwmg_out_stage.sv
// pwmg_out_stage: registered PWM and period-start flag.
// The compare uses the look-ahead count and duty so that the registered
// output lines up with the count register. Assumes evt comes from
// pwmg_counter and the duty look-ahead from pwmg_duty_latch.
module pwmg_out_stage
    import pwmg_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_evt_t         evt,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] duty_nxt,
    output logic             pwm_q,
    output logic             wrap_q
);

    logic pwm_d;

    // Compare for the cycle that follows this edge.
    always_comb begin
        pwm_d = (cnt_nxt < duty_nxt);
    end

    // Output registers, enable-qualified like the rest of the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else if (evt.step) begin
            pwm_q  <= pwm_d;
            wrap_q <= evt.roll;
        end
    end

    // The flag cannot survive two enabled edges in a row.
    assert_wrap_single_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q && evt.step |=> !wrap_q);

    // Outputs hold across a disabled edge.
    assert_out_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !evt.step |=> $stable(pwm_q) && $stable(wrap_q));

endmodule

// File: rtl/pwmg_gated_top.sv
// pwmg_gated_top: counter-based PWM generator with an enable-qualified clock.
// The gated register clock is realised as a clock enable on every flop.
// Assumes a single free-running clock and a synchronous active-low reset.
module pwmg_gated_top
    import pwmg_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_o,
    output logic             wrap_o
);

    localparam int unsigned PERIOD = period_len(CNT_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] duty_nxt;
    cnt_evt_t         evt;

    pwmg_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .evt     (evt)
    );

    pwmg_duty_latch #(.CNT_W(CNT_W)) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .roll     (evt.roll),
        .duty_in  (duty_in),
        .duty_q   (duty_q),
        .duty_nxt (duty_nxt)
    );

    pwmg_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .cnt_nxt  (cnt_nxt),
        .duty_nxt (duty_nxt),
        .pwm_q    (pwm_o),
        .wrap_q   (wrap_o)
    );

    // A zero captured duty never yields a high output.
    assert_zero_duty_low_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        duty_q == '0 |-> !pwm_o);

    // The flag only appears in the first cycle of a period.
    assert_wrap_at_start_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> cnt_q == '0);

    // The period length is at least a few cycles for a usable pulse.
    initial begin
        assert_period_sane_R3 : assert (PERIOD >= 4);
    end

endmodule

// File: tb/pwmg_gated_top_tb.sv
// pwmg_gated_top_tb: sweeps every duty value, duty changes every cycle,
// enable patterns and mid-run resets, against an arithmetic model.
module pwmg_gated_top_tb;

    localparam int W = 4;
    localparam int P = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] duty_in = '0;
    logic         pwm_o;
    logic         wrap_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state: position in period, captured duty, flag.
    int m_pos  = 0;
    int m_duty = 0;
    bit m_wrap = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    pwmg_gated_top #(.CNT_W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .duty_in (duty_in),
        .pwm_o   (pwm_o),
        .wrap_o  (wrap_o)
    );

    task automatic compare(input string req);
        bit exp_pwm;
        exp_pwm = (m_pos < m_duty);
        n_chk++;
        if (pwm_o !== exp_pwm) begin
            n_bad++;
            $display("FAIL %s pwm_o actual=%b expected=%b pos=%0d duty=%0d",
                     req, pwm_o, exp_pwm, m_pos, m_duty);
        end
        n_chk++;
        if (wrap_o !== m_wrap) begin
            n_bad++;
            $display("FAIL %s wrap_o actual=%b expected=%b pos=%0d",
                     req, wrap_o, m_wrap, m_pos);
        end
    endtask

    // One clock: drive at negedge, update model at the edge, check at next negedge.
    task automatic step(input bit r, input bit e, input int d, input string req);
        rst_n   = r;
        en      = e;
        duty_in = W'(d);
        @(posedge clk);
        if (!r) begin
            m_pos = 0; m_duty = 0; m_wrap = 1'b0;
        end else if (e) begin
            m_wrap = (m_pos == P - 1);
            if (m_pos == P - 1) m_duty = d;
            m_pos = (m_pos + 1) % P;
        end
        @(negedge clk);
        compare(req);
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        @(negedge clk);
        // R1: reset state, with enable high and a nonzero duty applied
        step(0, 1, 9, "R1");
        step(0, 1, 9, "R1");
        // R7: first period after reset stays low even with duty 12
        for (int i = 0; i < P; i++) step(1, 1, 12, "R7");
        // R4/R6: every duty held for two full periods
        for (int d = 0; d < P; d++) begin
            for (int i = 0; i < 2 * P; i++)
                step(1, 1, d, (d == 0 || d == P - 1) ? "R6" : "R4");
        end
        // R5: duty input changes every cycle; only rollover value matters
        for (int i = 0; i < 8 * P; i++) begin
            lfsr = nxt(lfsr);
            step(1, 1, int'(lfsr[3:0]), "R5");
        end
        // R2: enable toggling pattern with changing duty
        for (int i = 0; i < 600; i++) begin
            lfsr = nxt(lfsr);
            step(1, lfsr[5] | lfsr[9], int'(lfsr[3:0]), "R2");
        end
        // R2: long disabled stretch across a would-be rollover
        for (int i = 0; i < 3 * P; i++) step(1, 0, 5, "R2");
        for (int i = 0; i < 2 * P; i++) step(1, 1, 5, "R3");
        // R1: mid-run reset, then R7 again and recovery
        step(0, 0, 7, "R1");
        for (int i = 0; i < 3 * P; i++) step(1, 1, 7, "R3");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule